// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces every clock that a master-mode stereo audio serial port needs, all from one kernel clock. A linear divider divides the kernel clock by an odd or even ratio set by an 8-bit divide value and an odd bit. A shaping rule splits each divided period into a high phase and a low phase that differ by at most one kernel cycle. When the master clock output is switched on, the divided clock leaves the block as the master clock. A fixed second stage then divides it by 8 for 16-bit slots or by 4 for 32-bit slots to form the bit clock, so the master clock always runs at 256 times the sample rate. When the master clock output is switched off, the divided clock is itself the bit clock and the master clock pin stays low.

A word-select output marks the left slot (low) and the right slot (high). It changes only on falling edges of the bit clock. All outputs are registered in the kernel clock domain. Two single-cycle strobes mark bit clock edges, so the shifting logic downstream can run on the kernel clock alone. No data streams through the block, so it has no valid/ready interface. Every pin is a plain control or status signal.

Top module: `audio_clkgen`

## Requirements
- R1: The divider ratio is N = 2*D + ODD, where D is the effective divide value. With the master clock output off, each bit clock period is high for D kernel cycles and then low for D + ODD kernel cycles.
- R2: With the master clock output on, the master clock is high for D kernel cycles and low for D + ODD kernel cycles. The bit clock divides it by K (K = 8 when slot_wide is 0, K = 4 when slot_wide is 1) and is high for K/2*N and low for K/2*N kernel cycles.
- R3: With the master clock output off, the master clock pin stays low.
- R4: Let the slot length L be 16 when slot_wide is 0 and 32 when slot_wide is 1. Word select is low after enable, goes high at the L-th bit clock falling edge and low again at the 2L-th. It changes only together with a bit clock falling edge.
- R5: A divide value of 0 or 1 is treated as 2 and sets cfg_err to 1. Any other value clears cfg_err.
- R6: Configuration inputs are captured only while en is low. Changes while en is high do not affect the outputs or cfg_err.
- R7: One kernel clock edge after en is sampled low, bck, mck and ws are low. At the first edge where en is sampled high, bck and the divided clock go high and start a fresh period.
- R8: bck_rise is high exactly in the first kernel cycle in which bck is high. bck_fall is high exactly in the first kernel cycle in which bck is low after being high. The two strobes are never high together.
- R9: While rst_n is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; while low, dividers are cleared and configuration is captured |
| div_val | input | 8 | Linear divide value D |
| odd_sel | input | 1 | Adds one kernel cycle to the divider ratio |
| mck_out_en | input | 1 | Drives the master clock out and switches in the second divider stage |
| slot_wide | input | 1 | 0: 16-bit slots, 1: 32-bit slots |
| mck | output | 1 | Master clock |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 for left and 1 for right |
| bck_rise | output | 1 | One-cycle strobe on a bit clock rising edge |
| bck_fall | output | 1 | One-cycle strobe on a bit clock falling edge |
| cfg_err | output | 1 | Divide value below 2 was captured |

## Verification
The assertions assume the following about the inputs:
- rst_n is released synchronously.
- Configuration inputs are meant to be set only while en is low.
- en is the only input that can stop the clocks at an arbitrary cycle.

The stimulus follows these rules. It sets every configuration field several kernel cycles before raising en, and it drives inputs only on falling kernel edges. One directed test does change div_val while en is high, but only to show that the change has no effect. The restart checks drop en for at least one full cycle, so each measurement starts from cleared dividers.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  localparam int DIV_W = 8;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic             mck_on;
    logic             wide;
  } clk_cfg_t;
endpackage

// File: rtl/audio_lin_div.sv
module audio_lin_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  output logic             divclk,
  output logic             tick,
  output logic             hi_nxt
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic             last;

  // ratio 2*D+ODD is the divide value with the odd bit appended
  assign ratio  = {div, odd};
  assign last   = (cnt == ratio - 1'b1);
  // high phase covers the first D counts, low phase the remaining D+ODD
  assign hi_nxt = run && (cnt < {1'b0, div});
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      divclk <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      divclk <= 1'b0;
    end else begin
      cnt    <= last ? '0 : cnt + 1'b1;
      divclk <= hi_nxt;
    end
  end
endmodule

// File: rtl/audio_bck_stage.sv
module audio_bck_stage #(
  parameter int MDIV_NARROW = 8,
  parameter int MDIV_WIDE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mck_on,
  input  logic wide,
  input  logic tick,
  input  logic hi_nxt,
  output logic bck,
  output logic bck_nxt
);
  localparam int PH_W = $clog2(MDIV_NARROW);

  logic [PH_W-1:0] ph;
  logic [PH_W:0]   kdiv;
  logic [PH_W:0]   half;

  assign kdiv = wide ? (PH_W+1)'(MDIV_WIDE) : (PH_W+1)'(MDIV_NARROW);
  assign half = kdiv >> 1;

  always_comb begin
    if (!run)
      bck_nxt = 1'b0;
    else if (mck_on)
      bck_nxt = tick ? ({1'b0, ph} < half) : bck;
    else
      bck_nxt = hi_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      bck <= 1'b0;
    end else begin
      bck <= bck_nxt;
      if (!run)
        ph <= '0;
      else if (mck_on && tick)
        ph <= ({1'b0, ph} == kdiv - 1'b1) ? '0 : ph + 1'b1;
    end
  end
endmodule

// File: rtl/audio_ws_gen.sv
module audio_ws_gen #(
  parameter int SLOT_NARROW = 16,
  parameter int SLOT_WIDE   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wide,
  input  logic bck,
  input  logic bck_nxt,
  output logic ws,
  output logic bck_rise,
  output logic bck_fall
);
  localparam int FC_W = $clog2(2 * SLOT_WIDE);

  logic [FC_W:0] fcnt;
  logic [FC_W:0] slot;
  logic [FC_W:0] frame_last;
  logic          fall_ev;
  logic          bck_d;

  assign slot       = wide ? (FC_W+1)'(SLOT_WIDE) : (FC_W+1)'(SLOT_NARROW);
  assign frame_last = (slot << 1) - 1'b1;
  assign fall_ev    = bck & ~bck_nxt;
  assign bck_rise   = bck & ~bck_d;
  assign bck_fall   = bck_d & ~bck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt  <= '0;
      ws    <= 1'b0;
      bck_d <= 1'b0;
    end else if (!run) begin
      fcnt  <= '0;
      ws    <= 1'b0;
      bck_d <= 1'b0;
    end else begin
      bck_d <= bck;
      if (fall_ev) begin
        fcnt <= (fcnt == frame_last) ? '0 : fcnt + 1'b1;
        if (fcnt == slot - 1'b1)
          ws <= 1'b1;
        else if (fcnt == frame_last)
          ws <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clk_pkg::*;
#(
  parameter int MDIV_NARROW = 8,
  parameter int MDIV_WIDE   = 4,
  parameter int SLOT_NARROW = 16,
  parameter int SLOT_WIDE   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             odd_sel,
  input  logic             mck_out_en,
  input  logic             slot_wide,
  output logic             mck,
  output logic             bck,
  output logic             ws,
  output logic             bck_rise,
  output logic             bck_fall,
  output logic             cfg_err
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  clk_cfg_t cfg_q;
  logic     bad_div;
  logic     divclk, tick, hi_nxt, bck_nxt;

  assign bad_div = (div_val < MIN_DIV);

  // configuration is captured only while the block is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{div: MIN_DIV, odd: 1'b0, mck_on: 1'b0, wide: 1'b0};
      cfg_err <= 1'b0;
    end else if (!en) begin
      cfg_q.div    <= bad_div ? MIN_DIV : div_val;
      cfg_q.odd    <= odd_sel;
      cfg_q.mck_on <= mck_out_en;
      cfg_q.wide   <= slot_wide;
      cfg_err      <= bad_div;
    end
  end

  audio_lin_div #(.DIV_W(DIV_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .run(en),
    .div(cfg_q.div), .odd(cfg_q.odd),
    .divclk(divclk), .tick(tick), .hi_nxt(hi_nxt)
  );

  audio_bck_stage #(.MDIV_NARROW(MDIV_NARROW), .MDIV_WIDE(MDIV_WIDE)) u_bck (
    .clk(clk), .rst_n(rst_n), .run(en),
    .mck_on(cfg_q.mck_on), .wide(cfg_q.wide),
    .tick(tick), .hi_nxt(hi_nxt),
    .bck(bck), .bck_nxt(bck_nxt)
  );

  audio_ws_gen #(.SLOT_NARROW(SLOT_NARROW), .SLOT_WIDE(SLOT_WIDE)) u_ws (
    .clk(clk), .rst_n(rst_n), .run(en), .wide(cfg_q.wide),
    .bck(bck), .bck_nxt(bck_nxt),
    .ws(ws), .bck_rise(bck_rise), .bck_fall(bck_fall)
  );

  assign mck = cfg_q.mck_on & divclk;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mck,
  input logic bck,
  input logic ws,
  input logic bck_rise,
  input logic bck_fall,
  input logic cfg_err
);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bck_rise && bck_fall));

  // R8
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bck_rise |-> (bck && !$past(bck)));

  // R8
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bck_fall |-> (!bck && $past(bck)));

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bck && !mck && !ws));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(cfg_err));

  // R4
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ws) && $past(en)) |-> $fell(bck));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mck(mck), .bck(bck), .ws(ws),
  .bck_rise(bck_rise), .bck_fall(bck_fall), .cfg_err(cfg_err)
);

// File: tb/tb_audio_clkgen.sv
`timescale 1ns/1ps
module tb_audio_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div_val = 8'd2;
  logic       odd_sel = 1'b0;
  logic       mck_out_en = 1'b0;
  logic       slot_wide = 1'b0;
  logic       mck, bck, ws, bck_rise, bck_fall, cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_clkgen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val), .odd_sel(odd_sel),
    .mck_out_en(mck_out_en), .slot_wide(slot_wide), .mck(mck), .bck(bck),
    .ws(ws), .bck_rise(bck_rise), .bck_fall(bck_fall), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [7:0] div;
    logic       odd;
    logic       mck;
    logic       wide;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   1'b0, 1'b0, 1'b0},
    '{8'd5,   1'b1, 1'b0, 1'b1},
    '{8'd2,   1'b1, 1'b1, 1'b0},
    '{8'd4,   1'b0, 1'b1, 1'b1},
    '{8'd0,   1'b0, 1'b0, 1'b0},
    '{8'd1,   1'b1, 1'b1, 1'b1},
    '{8'd255, 1'b1, 1'b0, 1'b0}
  };

  localparam int GUARD = 40000;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drop en, apply configuration, raise en; returns at the first enabled sample
  task automatic start(input vec_t v);
    @(negedge clk);
    en = 1'b0;
    div_val = v.div; odd_sel = v.odd; mck_out_en = v.mck; slot_wide = v.wide;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int de, n, k, hi_e, lo_e, sl;
    int hi, lo, bad, g, nf, mh, ml, ch1, ch2;
    bit prev, pws;
    de = (v.div < 2) ? 2 : int'(v.div);
    n  = 2 * de + int'(v.odd);
    k  = v.wide ? 4 : 8;
    sl = v.wide ? 32 : 16;
    if (v.mck) begin hi_e = k / 2 * n; lo_e = hi_e; end
    else begin hi_e = de; lo_e = de + int'(v.odd); end

    // bit clock phases and strobes (R1, R2, R8)
    start(v);
    chk(cfg_err == (v.div < 2), "R5 cfg_err", int'(cfg_err), int'(v.div < 2));
    hi = 0; lo = 0; bad = 0; prev = 1'b0; g = 0;
    while (bck && g < GUARD) begin
      if (bck_rise != (bck && !prev) || bck_fall != (!bck && prev)) bad++;
      prev = bck; hi++; g++; @(negedge clk);
    end
    while (!bck && g < GUARD) begin
      if (bck_rise != (bck && !prev) || bck_fall != (!bck && prev)) bad++;
      prev = bck; lo++; g++; @(negedge clk);
    end
    if (bck_rise != (bck && !prev)) bad++;
    chk(hi == hi_e, v.mck ? "R2 bck high" : "R1 bck high", hi, hi_e);
    chk(lo == lo_e, v.mck ? "R2 bck low" : "R1 bck low", lo, lo_e);
    chk(bad == 0, "R8 strobe mismatches", bad, 0);

    // master clock (R2, R3)
    start(v);
    if (v.mck) begin
      mh = 0; ml = 0; g = 0;
      while (mck && g < GUARD) begin mh++; g++; @(negedge clk); end
      while (!mck && g < GUARD) begin ml++; g++; @(negedge clk); end
      chk(mh == de && ml == de + int'(v.odd), "R2 mck high/low", mh * 1000 + ml,
          de * 1000 + de + int'(v.odd));
    end else begin
      mh = 0;
      for (int i = 0; i < 3 * n; i++) begin
        if (mck) mh++;
        @(negedge clk);
      end
      chk(mh == 0, "R3 mck held low", mh, 0);
    end

    // word select (R4)
    start(v);
    nf = 0; ch1 = -1; ch2 = -1; bad = 0; pws = 1'b0; g = 0;
    chk(ws == 1'b0, "R4 ws starts low", int'(ws), 0);
    while (ch2 < 0 && g < 4 * GUARD) begin
      if (bck_fall) nf++;
      if (ws != pws) begin
        if (!bck_fall) bad++;
        if (ch1 < 0) ch1 = nf; else ch2 = nf;
      end
      pws = ws; g++; @(negedge clk);
    end
    chk(ch1 == sl && bad == 0, "R4 ws high at slot end", ch1, sl);
    chk(ch2 == 2 * sl && bad == 0, "R4 ws low at frame end", ch2, 2 * sl);
  endtask

  initial begin
    int hi, g;
    vec_t v;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({mck, bck, ws, bck_rise, bck_fall, cfg_err} == 6'b0, "R9 reset outputs",
        int'({mck, bck, ws, bck_rise, bck_fall, cfg_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: changes while enabled are ignored
    v = '{8'd3, 1'b0, 1'b0, 1'b0};
    start(v);
    div_val = 8'd0; odd_sel = 1'b1; mck_out_en = 1'b1;
    g = 0;
    while (bck && g < GUARD) begin g++; @(negedge clk); end
    while (!bck && g < GUARD) begin g++; @(negedge clk); end
    hi = 0;
    while (bck && g < GUARD) begin hi++; g++; @(negedge clk); end
    chk(hi == 3, "R6 divide unchanged while enabled", hi, 3);
    chk(cfg_err == 1'b0 && mck == 1'b0, "R6 cfg_err and mck unchanged",
        int'({cfg_err, mck}), 0);

    // R7: disable clears outputs, restart begins with bck high
    v = '{8'd2, 1'b0, 1'b1, 1'b0};
    start(v);
    repeat (37) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk({bck, mck, ws} == 3'b0, "R7 outputs cleared on disable", int'({bck, mck, ws}), 0);
    en = 1'b1;
    @(negedge clk);
    chk(bck && mck && bck_rise, "R7 clean restart", int'({bck, mck, bck_rise}), 7);

    summary();
  end
endmodule